// File: doc/BRIEF.md
# SD/MMC Single-Bit Data Path Controller

This block drives and samples the single data line of an SD/MMC host, one bit per clock. It moves bytes between the serial line and an external data FIFO. Received bytes go to the FIFO write side. Bytes to be sent come from the FIFO read side, which is show-ahead: `rd_data_i` already holds the head byte whenever `empty_i` is low. A transfer starts on a rising edge of `en_i`. At that edge the direction, the mode, the total byte count, the block size and the tail bit count are captured.

Two framing modes are supported. Block mode closes each block with a CRC16 and an end bit, and after each sent block it waits for the card's CRC status token and busy release. Stream mode is one continuous run of data bits with no CRC. In stream mode the last byte may be cut short to a programmed number of bits. A programmable timeout watches two situations: waiting for a card's start bit, and waiting for the card to answer after a sent block. Four sticky flags report the outcome: timeout, CRC failure, FIFO error and data end.

Top module: `sdd_data_path`

## Requirements
- R1: After reset and while idle, `dat_oe_o`=0, `dat_o`=1, `wr_en_o`=0, `rd_en_o`=0 and all four status flags are 0.
- R2: A rising edge of `en_i` clears all flags and starts a transfer. `send_i`=1 selects host-to-card and `send_i`=0 selects card-to-host. `stream_i`=1 selects stream mode and `stream_i`=0 selects block mode. The byte count comes from `len_i` and the block size from `blk_len_i`. A transfer with `len_i`=0 returns to idle at once.
- R3: On receive, a low bit on `dat_i` starts a block. Each following bit is taken MSB first, and every 8 bits form a byte that is written with a one-cycle `wr_en_o` pulse. In block mode, after `blk_len_i` bytes (or the last byte of the transfer), the card sends a 16-bit CRC and then a high end bit. The CRC uses polynomial 0x1021, initial value 0, and is computed over the block's data bits MSB first. A match waits for the next start bit. `data_end_o` rises when the byte count reaches zero.
- R4: On receive, a CRC mismatch or a low end bit sets `crc_fail_o` and ends the transfer.
- R5: In stream mode with `tail_bits_i`=N (1..7), the final byte carries only N bits. On receive, that byte is written left-aligned with zeros in the low bits. On send, only its N most significant bits are driven. `tail_bits_i`=0 means the final byte is whole.
- R6: While waiting for a start bit, if `tmo_i` cycles pass with no start bit, `tmo_o` is set and the transfer ends.
- R7: If `full_i` is high in the cycle a received byte completes, `fifo_err_o` is set and that byte is not written.
- R8: On send in block mode, each block is driven as a low start bit, then the data bytes MSB first, then the CRC16 (same definition as R3) MSB first, then a high end bit. `dat_oe_o` is high for exactly these bits. Each byte is popped with `rd_en_o`.
- R9: After a sent block, the card returns a token made of a low start bit, three status bits and an end bit. Status 010 is positive: the block waits for `dat_i` to go high and then spends at least two cycles before the next block's start bit (exactly 3 negedge samples of `dat_oe_o`=0 counting the release sample). Any other status sets `crc_fail_o` and ends the transfer.
- R10: If the post-block wait (token plus busy) lasts `tmo_i` cycles, `tmo_o` is set and the transfer ends.
- R11: If the FIFO is empty when a further send byte is needed, `fifo_err_o` is set, the line is released and the transfer ends.
- R12: In stream-mode send, a low start bit is followed by all data bits back to back. There is no CRC, and the line is released right after the last data bit.
- R13: Clearing `en_i` ends any transfer, and `dat_oe_o` is low from the next cycle.
- R14: Flags stay set until the next transfer start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one line bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transfer enable; rising edge starts, low aborts |
| send_i | input | 1 | 1 host-to-card, 0 card-to-host |
| stream_i | input | 1 | 1 stream mode, 0 block mode |
| len_i | input | CNT_W | Total bytes in the transfer |
| blk_len_i | input | BLK_W | Bytes per block (block mode) |
| tail_bits_i | input | 3 | Bits in the final stream byte, 0 = 8 |
| tmo_i | input | TMO_W | Timeout period in cycles |
| dat_i | input | 1 | Serial data line sampled from the card |
| dat_o | output | 1 | Serial data driven to the card |
| dat_oe_o | output | 1 | Drive enable for `dat_o` |
| wr_data_o | output | 8 | Received byte to the FIFO |
| wr_en_o | output | 1 | FIFO write strobe |
| full_i | input | 1 | FIFO full |
| rd_data_i | input | 8 | Head byte of the FIFO (show-ahead) |
| rd_en_o | output | 1 | FIFO pop strobe |
| empty_i | input | 1 | FIFO empty |
| tmo_o | output | 1 | Sticky timeout flag |
| crc_fail_o | output | 1 | Sticky CRC or status failure flag |
| fifo_err_o | output | 1 | Sticky overrun/underrun flag |
| data_end_o | output | 1 | Sticky byte count reached zero |

## Verification
Receive is tried with two good blocks, a block with one corrupted CRC bit, a stream ending in a 3-bit tail, a full FIFO and a silent line. Together these separate correct CRC and byte assembly from wrong checking, lost tail alignment, writes past a full FIFO and a dead timer. Send is tried with two blocks compared bit for bit, a negative status token, a card that never releases busy, a FIFO holding too few bytes, a 4-bit stream tail and an enable dropped mid-byte. These separate framing, CRC generation, the dwell before the second block, token decoding, the busy timeout, underrun handling and abort.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_R, ST_RECV, ST_WAIT_S, ST_SEND, ST_BUSY
  } state_e;

  // sub-phase inside a state
  typedef enum logic [2:0] {
    PH_HEAD, PH_BODY, PH_CRC, PH_TAIL, PH_HOLD
  } ph_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction
endpackage

// File: rtl/sdd_crc16.sv
module sdd_crc16
  import sdd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        upd_i,
  input  logic        shift_i,
  input  logic        din_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clr_i)   crc_q <= '0;
    else if (upd_i)   crc_q <= crc_step(crc_q, din_i);
    else if (shift_i) crc_q <= {crc_q[14:0], 1'b0};
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/sdd_tmo_timer.sv
module sdd_tmo_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [TMO_W-1:0] period_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i)             cnt_q <= '0;
    else if (cnt_q != '1)        cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q >= period_i);
endmodule

// File: rtl/sdd_data_path.sv
module sdd_data_path
  import sdd_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BLK_W = 12,
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             send_i,
  input  logic             stream_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [BLK_W-1:0] blk_len_i,
  input  logic [2:0]       tail_bits_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic             dat_i,
  output logic             dat_o,
  output logic             dat_oe_o,
  output logic [7:0]       wr_data_o,
  output logic             wr_en_o,
  input  logic             full_i,
  input  logic [7:0]       rd_data_i,
  output logic             rd_en_o,
  input  logic             empty_i,
  output logic             tmo_o,
  output logic             crc_fail_o,
  output logic             fifo_err_o,
  output logic             data_end_o
);
  localparam logic [CNT_W-1:0] DCNT_ONE = CNT_W'(1);
  localparam logic [BLK_W-1:0] BCNT_ONE = BLK_W'(1);

  state_e           st_q;
  ph_e              ph_q;
  logic [3:0]       bit_q;
  logic [7:0]       sh_q;
  logic [1:0]       tok_q;
  logic [CNT_W-1:0] dcnt_q;
  logic [BLK_W-1:0] bcnt_q, blk_q;
  logic             stream_q, ws_q, en_q;
  logic [2:0]       tail_q;
  logic             tmo_q, crc_fail_q, fifo_err_q, data_end_q;
  logic             wr_en_q;
  logic [7:0]       wr_data_q;

  logic [2:0]  last_idx;
  logic        byte_done, dcnt_one, bcnt_one, seg_end;
  logic        tmr_run, tmr_exp;
  logic        ws_go, tx_next, start_det;
  logic        crc_clr, crc_upd, crc_shift, crc_din;
  logic [15:0] crc_q;
  logic [7:0]  rx_byte;

  // final stream byte may be short (R5)
  assign last_idx  = (stream_q && dcnt_q == DCNT_ONE && tail_q != 3'd0) ? tail_q - 3'd1 : 3'd7;
  assign byte_done = (bit_q[2:0] == last_idx);
  assign dcnt_one  = (dcnt_q == DCNT_ONE);
  assign bcnt_one  = (bcnt_q == BCNT_ONE);
  assign seg_end   = stream_q ? dcnt_one : (bcnt_one || dcnt_one);
  assign rx_byte   = {sh_q[6:0], dat_i} << (3'd7 - bit_q[2:0]);

  assign tmr_run   = (st_q == ST_WAIT_R) || (st_q == ST_BUSY);
  assign start_det = en_i && st_q == ST_WAIT_R && dcnt_q != '0 && !tmr_exp && !dat_i;
  assign ws_go     = en_i && st_q == ST_WAIT_S && dcnt_q != '0 && ws_q && !empty_i;
  assign tx_next   = en_i && st_q == ST_SEND && ph_q == PH_BODY && byte_done && !seg_end && !empty_i;
  assign rd_en_o   = ws_go || tx_next;

  assign crc_clr   = start_det || ws_go;
  assign crc_upd   = (st_q == ST_RECV && (ph_q == PH_BODY || ph_q == PH_CRC)) ||
                     (st_q == ST_SEND && ph_q == PH_BODY);
  assign crc_din   = (st_q == ST_SEND) ? sh_q[7] : dat_i;
  assign crc_shift = (st_q == ST_SEND && ph_q == PH_CRC);

  sdd_crc16 u_crc (
    .clk_i, .rst_ni,
    .clr_i(crc_clr), .upd_i(crc_upd), .shift_i(crc_shift), .din_i(crc_din),
    .crc_o(crc_q)
  );

  sdd_tmo_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk_i, .rst_ni,
    .run_i(tmr_run), .period_i(tmo_i), .expired_o(tmr_exp)
  );

  always_comb begin
    dat_o = 1'b1;
    if (st_q == ST_SEND) begin
      case (ph_q)
        PH_HEAD: dat_o = 1'b0;
        PH_BODY: dat_o = sh_q[7];
        PH_CRC:  dat_o = crc_q[15];
        default: dat_o = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;   ph_q <= PH_HEAD;  bit_q <= '0;   sh_q <= '0;
      tok_q <= '0;       dcnt_q <= '0;     bcnt_q <= '0;  blk_q <= '0;
      stream_q <= 1'b0;  ws_q <= 1'b0;     en_q <= 1'b0;  tail_q <= '0;
      tmo_q <= 1'b0;     crc_fail_q <= 1'b0; fifo_err_q <= 1'b0; data_end_q <= 1'b0;
      wr_en_q <= 1'b0;   wr_data_q <= '0;
    end else begin
      en_q    <= en_i;
      wr_en_q <= 1'b0;
      if (!en_i) begin
        st_q <= ST_IDLE;                       // R13
      end else begin
        case (st_q)
          ST_IDLE: if (!en_q) begin             // R2
            tmo_q <= 1'b0; crc_fail_q <= 1'b0; fifo_err_q <= 1'b0; data_end_q <= 1'b0;
            dcnt_q <= len_i; blk_q <= blk_len_i; stream_q <= stream_i; tail_q <= tail_bits_i;
            ws_q <= 1'b0;
            st_q <= send_i ? ST_WAIT_S : ST_WAIT_R;
          end
          ST_WAIT_R: begin
            if (dcnt_q == '0)  st_q <= ST_IDLE;
            else if (tmr_exp) begin tmo_q <= 1'b1; st_q <= ST_IDLE; end   // R6
            else if (!dat_i) begin
              st_q <= ST_RECV; ph_q <= PH_BODY; bit_q <= '0; bcnt_q <= blk_q;
            end
          end
          ST_RECV: begin
            case (ph_q)
              PH_BODY: begin
                sh_q  <= {sh_q[6:0], dat_i};
                bit_q <= bit_q + 4'd1;
                if (byte_done) begin
                  bit_q <= '0;
                  if (full_i) begin
                    fifo_err_q <= 1'b1; st_q <= ST_WAIT_R;               // R7
                  end else begin
                    wr_en_q <= 1'b1; wr_data_q <= rx_byte;
                    dcnt_q <= dcnt_q - 1'b1; bcnt_q <= bcnt_q - 1'b1;
                    if (dcnt_one) data_end_q <= 1'b1;
                    if (seg_end) begin
                      if (stream_q) st_q <= ST_WAIT_R;
                      else          ph_q <= PH_CRC;
                    end
                  end
                end
              end
              PH_CRC: begin
                bit_q <= bit_q + 4'd1;
                if (bit_q == 4'd15) begin bit_q <= '0; ph_q <= PH_TAIL; end
              end
              default: begin
                // residue zero after CRC bits means match (R4)
                if (crc_q == '0 && dat_i) st_q <= ST_WAIT_R;
                else begin crc_fail_q <= 1'b1; st_q <= ST_IDLE; end
              end
            endcase
          end
          ST_WAIT_S: begin
            ws_q <= 1'b1;
            if (dcnt_q == '0) st_q <= ST_IDLE;
            else if (ws_q && !empty_i) begin
              st_q <= ST_SEND; ph_q <= PH_HEAD; sh_q <= rd_data_i; bcnt_q <= blk_q;
            end
          end
          ST_SEND: begin
            case (ph_q)
              PH_HEAD: begin ph_q <= PH_BODY; bit_q <= '0; end
              PH_BODY: begin
                sh_q  <= {sh_q[6:0], 1'b0};
                bit_q <= bit_q + 4'd1;
                if (byte_done) begin
                  bit_q <= '0;
                  dcnt_q <= dcnt_q - 1'b1; bcnt_q <= bcnt_q - 1'b1;
                  if (dcnt_one) data_end_q <= 1'b1;
                  if (seg_end) begin
                    if (stream_q) st_q <= ST_IDLE;                       // R12
                    else          ph_q <= PH_CRC;
                  end else if (empty_i) begin
                    fifo_err_q <= 1'b1; st_q <= ST_IDLE;                 // R11
                  end else sh_q <= rd_data_i;
                end
              end
              PH_CRC: begin
                bit_q <= bit_q + 4'd1;
                if (bit_q == 4'd15) begin bit_q <= '0; ph_q <= PH_TAIL; end
              end
              default: begin st_q <= ST_BUSY; ph_q <= PH_HEAD; end
            endcase
          end
          ST_BUSY: begin
            if (tmr_exp) begin tmo_q <= 1'b1; st_q <= ST_IDLE; end      // R10
            else begin
              case (ph_q)
                PH_HEAD: if (!dat_i) begin ph_q <= PH_BODY; bit_q <= '0; end
                PH_BODY: begin
                  tok_q <= {tok_q[0], dat_i};
                  bit_q <= bit_q + 4'd1;
                  if (bit_q == 4'd2) begin
                    if ({tok_q, dat_i} == 3'b010) ph_q <= PH_TAIL;       // R9
                    else begin crc_fail_q <= 1'b1; st_q <= ST_IDLE; end
                  end
                end
                PH_TAIL: ph_q <= PH_HOLD;
                default: if (dat_i) begin st_q <= ST_WAIT_S; ws_q <= 1'b0; end
              endcase
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign dat_oe_o   = (st_q == ST_SEND);
  assign wr_en_o    = wr_en_q;
  assign wr_data_o  = wr_data_q;
  assign tmo_o      = tmo_q;
  assign crc_fail_o = crc_fail_q;
  assign fifo_err_o = fifo_err_q;
  assign data_end_o = data_end_q;
endmodule

// File: rtl/sdd_data_path_chk.sv
module sdd_data_path_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic dat_o,
  input logic dat_oe_o,
  input logic wr_en_o,
  input logic full_i,
  input logic tmo_o,
  input logic crc_fail_o,
  input logic fifo_err_o
);
  assert_start_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dat_oe_o) |-> !dat_o);

  assert_no_write_when_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(!full_i));

  assert_abort_releases_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!dat_oe_o && !wr_en_o));

  assert_tmo_sticky_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tmo_o) && $past(en_i, 2)) |-> tmo_o);

  assert_crc_fail_sticky_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(crc_fail_o) && $past(en_i, 2)) |-> crc_fail_o);

  assert_fifo_err_sticky_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fifo_err_o) && $past(en_i, 2)) |-> fifo_err_o);
endmodule

bind sdd_data_path sdd_data_path_chk chk_i (.*);

// File: tb/sdd_data_path_tb_top.sv
module sdd_data_path_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic en_i = 0, send_i = 0, stream_i = 0, dat_i = 1, full_i = 0;
  logic [15:0] len_i = 0;
  logic [11:0] blk_len_i = 0;
  logic [2:0]  tail_bits_i = 0;
  logic [15:0] tmo_i = 0;
  logic dat_o, dat_oe_o, wr_en_o, rd_en_o, empty_i;
  logic tmo_o, crc_fail_o, fifo_err_o, data_end_o;
  logic [7:0] wr_data_o, rd_data_i;

  logic [7:0] txq [16];
  logic [7:0] rxq [16];
  int tx_n = 0, tx_rd = 0, rx_n = 0;
  logic fifo_clr = 0;
  int n_chk = 0, n_fail = 0;
  logic got [0:63];
  logic exp_b [0:63];

  assign empty_i   = (tx_rd >= tx_n);
  assign rd_data_i = txq[tx_rd[3:0]];

  always @(posedge clk) begin
    if (fifo_clr) begin tx_rd <= 0; rx_n <= 0; end
    else begin
      if (rd_en_o) tx_rd <= tx_rd + 1;
      if (wr_en_o) begin rxq[rx_n[3:0]] <= wr_data_o; rx_n <= rx_n + 1; end
    end
  end

  sdd_data_path dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i, .send_i, .stream_i, .len_i, .blk_len_i,
    .tail_bits_i, .tmo_i, .dat_i, .dat_o, .dat_oe_o, .wr_data_o, .wr_en_o, .full_i,
    .rd_data_i, .rd_en_o, .empty_i, .tmo_o, .crc_fail_o, .fifo_err_o, .data_end_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0);
  endfunction

  task automatic card_bit(input logic b);
    dat_i = b;
    @(negedge clk);
  endtask

  task automatic start_xfer(input logic snd, input logic strm, input int len, input int blk,
                            input int tail, input int tmo);
    send_i = snd; stream_i = strm; len_i = 16'(len); blk_len_i = 12'(blk);
    tail_bits_i = 3'(tail); tmo_i = 16'(tmo);
    en_i = 1;
    @(negedge clk);
  endtask

  task automatic stop_xfer();
    en_i = 0; dat_i = 1; full_i = 0;
    repeat (2) @(negedge clk);
    fifo_clr = 1; @(negedge clk); fifo_clr = 0; tx_n = 0;
    @(negedge clk);
  endtask

  // card sends one block, optional CRC corruption; returns nothing
  task automatic card_block(input int first, input int nbytes, input logic [15:0] crc_xor);
    logic [15:0] c = 16'h0;
    card_bit(0);
    for (int k = 0; k < nbytes; k++)
      for (int i = 7; i >= 0; i--) begin
        logic b = rxq_src(first + k) >> i;
        c = crc_bit(c, b);
        card_bit(b);
      end
    c = c ^ crc_xor;
    for (int i = 15; i >= 0; i--) card_bit(c[i]);
    card_bit(1);
    card_bit(1);
    card_bit(1);
  endtask

  function automatic logic [7:0] rxq_src(input int k);
    return 8'(8'h3C + k * 37);
  endfunction

  // waits for drive enable, collects n bits; returns negedges waited
  task automatic capture(input int n, output int waited);
    waited = 0;
    while (!dat_oe_o && waited < 400) begin @(negedge clk); waited++; end
    for (int i = 0; i < n; i++) begin
      got[i] = dat_oe_o ? dat_o : 1'bx;
      @(negedge clk);
    end
  endtask

  // expected frame for bytes txq[first..first+nb-1]; last byte limited to lastbits
  task automatic build_frame(input int first, input int nb, input int lastbits,
                             input logic with_crc, output int nbits);
    logic [15:0] c = 16'h0;
    nbits = 0;
    exp_b[nbits++] = 1'b0;
    for (int k = 0; k < nb; k++) begin
      int lim = (k == nb - 1) ? lastbits : 8;
      for (int i = 7; i > 7 - lim; i--) begin
        logic b = txq[first + k][i];
        c = crc_bit(c, b);
        exp_b[nbits++] = b;
      end
    end
    if (with_crc) begin
      for (int i = 15; i >= 0; i--) exp_b[nbits++] = c[i];
      exp_b[nbits++] = 1'b1;
    end
  endtask

  task automatic cmp_frame(input string tag, input int nbits);
    int bad = 0;
    for (int i = 0; i < nbits; i++) if (got[i] !== exp_b[i]) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic token(input logic [2:0] st, input int busy_cycles);
    card_bit(0);
    card_bit(st[2]); card_bit(st[1]); card_bit(st[0]);
    card_bit(1);
    repeat (busy_cycles) card_bit(0);
    dat_i = 1;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 dat_oe_o idle", dat_oe_o, 0);
    chk("R1 dat_o idle", dat_o, 1);
    chk("R1 strobes idle", {wr_en_o, rd_en_o}, 0);
    chk("R1 flags idle", {tmo_o, crc_fail_o, fifo_err_o, data_end_o}, 0);
  endtask

  task automatic t_rx_block();
    start_xfer(0, 0, 8, 4, 0, 1000);
    repeat (2) card_bit(1);
    card_block(0, 4, 16'h0);
    card_block(4, 4, 16'h0);
    repeat (4) @(negedge clk);
    chk("R3 rx byte count", rx_n, 8);
    for (int k = 0; k < 8; k++) chk("R3 rx byte value", rxq[k], rxq_src(k));
    chk("R3 data_end", data_end_o, 1);
    chk("R3 no crc_fail", crc_fail_o, 0);
    chk("R2 no tmo", tmo_o, 0);
    stop_xfer();
  endtask

  task automatic t_rx_badcrc();
    start_xfer(0, 0, 8, 4, 0, 1000);
    card_bit(1);
    card_block(0, 4, 16'h0100);
    repeat (3) @(negedge clk);
    chk("R4 crc_fail on bad crc", crc_fail_o, 1);
    chk("R4 bytes before stop", rx_n, 4);
    chk("R4 no data_end", data_end_o, 0);
    stop_xfer();
    chk("R14 crc_fail held after stop", crc_fail_o, 1);
    start_xfer(0, 0, 0, 4, 0, 1000);
    repeat (2) @(negedge clk);
    chk("R2 flags cleared on start", crc_fail_o, 0);
    chk("R2 zero length ends", data_end_o, 0);
    stop_xfer();
  endtask

  task automatic t_rx_stream_tail();
    logic [7:0] b0 = 8'hA7, b1 = 8'h6D;
    start_xfer(0, 1, 2, 4, 3, 1000);
    card_bit(1);
    card_bit(0);
    for (int i = 7; i >= 0; i--) card_bit(b0[i]);
    for (int i = 7; i >= 5; i--) card_bit(b1[i]);
    dat_i = 1;
    repeat (4) @(negedge clk);
    chk("R5 stream rx count", rx_n, 2);
    chk("R5 stream rx full byte", rxq[0], b0);
    chk("R5 stream rx tail byte", rxq[1], b1 & 8'hE0);
    chk("R5 stream data_end", data_end_o, 1);
    stop_xfer();
  endtask

  task automatic t_rx_timeout();
    start_xfer(0, 0, 4, 4, 0, 20);
    repeat (40) card_bit(1);
    chk("R6 rx timeout flag", tmo_o, 1);
    chk("R6 rx nothing written", rx_n, 0);
    stop_xfer();
  endtask

  task automatic t_rx_overrun();
    full_i = 1;
    start_xfer(0, 0, 4, 4, 0, 1000);
    card_bit(1);
    card_bit(0);
    for (int i = 7; i >= 0; i--) card_bit(i[0]);
    repeat (3) card_bit(1);
    chk("R7 overrun flag", fifo_err_o, 1);
    chk("R7 overrun no write", rx_n, 0);
    stop_xfer();
  endtask

  task automatic load_tx(input int n);
    for (int k = 0; k < n; k++) txq[k] = 8'(8'h91 + k * 29);
    tx_n = n;
  endtask

  task automatic t_tx_block();
    int w, nb;
    load_tx(8);
    start_xfer(1, 0, 8, 4, 0, 1000);
    capture(50, w);
    build_frame(0, 4, 8, 1, nb);
    cmp_frame("R8 first block frame", nb);
    token(3'b010, 4);
    capture(50, w);
    chk("R9 dwell before second block", w, 3);
    build_frame(4, 4, 8, 1, nb);
    cmp_frame("R8 second block frame", nb);
    token(3'b010, 2);
    repeat (6) @(negedge clk);
    chk("R8 all bytes popped", tx_rd, 8);
    chk("R8 data_end", data_end_o, 1);
    chk("R9 positive status no fail", crc_fail_o, 0);
    chk("R9 line released", dat_oe_o, 0);
    stop_xfer();
  endtask

  task automatic t_tx_neg_status();
    int w;
    load_tx(4);
    start_xfer(1, 0, 4, 4, 0, 1000);
    capture(50, w);
    token(3'b101, 0);
    repeat (3) @(negedge clk);
    chk("R9 negative status crc_fail", crc_fail_o, 1);
    chk("R9 no timeout", tmo_o, 0);
    stop_xfer();
  endtask

  task automatic t_tx_busy_timeout();
    int w;
    load_tx(4);
    start_xfer(1, 0, 4, 4, 0, 30);
    capture(50, w);
    token(3'b010, 60);
    chk("R10 busy timeout flag", tmo_o, 1);
    chk("R10 no crc_fail", crc_fail_o, 0);
    stop_xfer();
  endtask

  task automatic t_tx_underrun();
    int w;
    load_tx(1);
    start_xfer(1, 0, 4, 4, 0, 1000);
    capture(9, w);
    chk("R11 line released after underrun", dat_oe_o, 0);
    chk("R11 underrun flag", fifo_err_o, 1);
    stop_xfer();
  endtask

  task automatic t_tx_stream_tail();
    int w, nb;
    load_tx(2);
    start_xfer(1, 1, 2, 4, 4, 1000);
    capture(13, w);
    build_frame(0, 2, 4, 0, nb);
    cmp_frame("R12 stream frame with R5 tail", nb);
    chk("R12 released after last bit", dat_oe_o, 0);
    chk("R12 stream data_end", data_end_o, 1);
    stop_xfer();
  endtask

  task automatic t_en_clear();
    int w;
    load_tx(4);
    start_xfer(1, 0, 4, 4, 0, 1000);
    capture(5, w);
    chk("R13 driving before abort", dat_oe_o, 1);
    en_i = 0;
    @(negedge clk);
    chk("R13 released after abort", dat_oe_o, 0);
    stop_xfer();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_rx_block();
    t_rx_badcrc();
    t_rx_stream_tail();
    t_rx_timeout();
    t_rx_overrun();
    t_tx_block();
    t_tx_neg_status();
    t_tx_busy_timeout();
    t_tx_underrun();
    t_tx_stream_tail();
    t_en_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule